// File: doc/BRIEF.md
# I/Q Sample FIFO with Frame-Aligned Write-Pointer Reset

This block is an eight-entry buffer for paired I and Q samples. Samples arrive in a data-interface clock domain and are consumed in a converter clock domain. Startup position is made repeatable through a framing input. When that input stays high for a full I-plus-Q load interval, the write pointer is forced to a programmable phase offset instead of zero. The distance between write and read positions, and with it the pipeline latency, is then the same after every power-up.

The read pointer has its own restart, driven by an external synchronization input. That input is sampled on either the rising or the falling edge of the converter clock, chosen by a control bit. A rising edge of the sampled value clears the read pointer to zero. A mode bit switches frame-driven write-pointer loading on (0) or off (1). The write pointer is carried into the converter domain in Gray code through two flops, for use by the read side.

Top module: `iq_phase_fifo`

## Requirements
- R1: Both pointers are ADDR_W (default 3) bits wide. The write pointer advances by one on each write-clock rising edge with `wrEn` high, and the read pointer by one on each read-clock rising edge with `rdEn` high. Each wraps from 7 to 0.
- R2: With `modeSel` = 0, `frameIn` must be sampled high on LOAD_CYCLES (default 2) consecutive write-clock rising edges. On the last of those edges the write pointer loads `phaseOffset`.
- R3: A frame pulse sampled high on fewer than LOAD_CYCLES consecutive edges causes no load. The write pointer keeps counting writes only.
- R4: A frame held high beyond qualification loads the pointer only once. Later writes advance it from the offset in the same cycle stream.
- R5: With `modeSel` = 1, `frameIn` has no effect on the write pointer.
- R6: A write on the loading edge stores its sample at slot `phaseOffset`, and the pointer becomes `phaseOffset`+1. A loading edge without a write leaves the pointer at exactly `phaseOffset`.
- R7: A 0-to-1 change of the sampled `syncIn` clears the read pointer to 0 on a read-clock rising edge. Holding `syncIn` high does not clear it again.
- R8: With `syncEdgeSel` = 0, `syncIn` is sampled on read-clock rising edges, so a rise placed just after a rising edge clears the pointer on the second following rising edge. With `syncEdgeSel` = 1, it is sampled on falling edges and the clear lands on the first following rising edge.
- R9: `rdI`/`rdQ` show, without a clock, the I/Q pair stored at the slot named by `rdPtr`.
- R10: `wrPtrRdDom` gives the write pointer as seen in the read domain. A write-pointer change appears there on the second read-clock rising edge after it, not the first.
- R11: While the resets are low, `wrPtr`, `rdPtr` and `wrPtrRdDom` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Data-interface clock |
| wrRstN | input | 1 | Active-low asynchronous reset, write domain |
| wrEn | input | 1 | Write one I/Q pair this cycle |
| wrI | input | DATA_W | I sample to store |
| wrQ | input | DATA_W | Q sample to store |
| frameIn | input | 1 | Framing input that requests the write-pointer load |
| phaseOffset | input | ADDR_W | Value loaded into the write pointer on a qualified frame |
| modeSel | input | 1 | 0: frame loading enabled; 1: frame ignored |
| rdClk | input | 1 | Converter clock |
| rdRstN | input | 1 | Active-low asynchronous reset, read domain |
| rdEn | input | 1 | Advance the read pointer this cycle |
| syncIn | input | 1 | External synchronization input that restarts the read pointer |
| syncEdgeSel | input | 1 | 0: sample syncIn on rising rdClk edges; 1: on falling edges |
| rdI | output | DATA_W | I sample at the read pointer |
| rdQ | output | DATA_W | Q sample at the read pointer |
| wrPtr | output | ADDR_W | Write pointer, write domain |
| rdPtr | output | ADDR_W | Read pointer, read domain |
| wrPtrRdDom | output | ADDR_W | Write pointer after crossing into the read domain |

## Verification
The bench targets frame qualification at its edge. A one-cycle pulse must be ignored, a two-cycle pulse must load, and a held frame must not load a second time. A qualifier that is one cycle short would load on the single-cycle pulse, and one that re-arms would drag the pointer back to the offset every cycle. Loading edges with and without a write tell apart a design that drops or misplaces the coinciding sample. Running the same sync stimulus under both edge selections exposes a design that ignores the select, since its clear lands one cycle off. Sampling the crossed pointer between the first and second read edges catches a crossing with one flop too few.

// File: rtl/iq_fifo_pkg.sv
`timescale 1ns/1ps
package iq_fifo_pkg;

  // Strobes from control to datapath, one per cycle in their own domain.
  typedef struct packed {
    logic wrEn;        // write domain: store a pair
    logic wrPtrLoad;   // write domain: force write pointer to offset
    logic rdEn;        // read domain: advance read pointer
    logic rdPtrClear;  // read domain: clear read pointer
  } fifoStrobes_t;

endpackage

// File: rtl/iq_fifo_ctrl.sv
`timescale 1ns/1ps
module iq_fifo_ctrl
  import iq_fifo_pkg::*;
#(
  parameter int LOAD_CYCLES = 2
) (
  input  logic         wrClk,
  input  logic         wrRstN,
  input  logic         wrEn,
  input  logic         frameIn,
  input  logic         modeSel,
  input  logic         rdClk,
  input  logic         rdRstN,
  input  logic         rdEn,
  input  logic         syncIn,
  input  logic         syncEdgeSel,
  output fifoStrobes_t strobes
);

  localparam int CNT_W = $clog2(LOAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(LOAD_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOAD_CYCLES - 1);

  // Frame qualifier: counts consecutive high samples, saturates so that
  // a held frame fires only once.
  logic [CNT_W-1:0] frameCnt;
  logic             frameQual;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      frameCnt <= '0;
    end else if (!frameIn || modeSel) begin
      frameCnt <= '0;
    end else if (frameCnt != CNT_SAT) begin
      frameCnt <= frameCnt + 1'b1;
    end
  end

  assign frameQual = frameIn && !modeSel && (frameCnt == CNT_LAST);

  // Sync sampling on both converter-clock edges; the select picks one.
  logic syncOnRise;
  logic syncOnFall;
  logic syncSel;
  logic syncSelPrev;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) syncOnRise <= 1'b0;
    else         syncOnRise <= syncIn;
  end

  always_ff @(negedge rdClk or negedge rdRstN) begin
    if (!rdRstN) syncOnFall <= 1'b0;
    else         syncOnFall <= syncIn;
  end

  assign syncSel = syncEdgeSel ? syncOnFall : syncOnRise;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) syncSelPrev <= 1'b0;
    else         syncSelPrev <= syncSel;
  end

  always_comb begin
    strobes.wrEn       = wrEn;
    strobes.wrPtrLoad  = frameQual;
    strobes.rdEn       = rdEn;
    strobes.rdPtrClear = syncSel && !syncSelPrev;
  end

endmodule

// File: rtl/iq_fifo_dp.sv
`timescale 1ns/1ps
module iq_fifo_dp
  import iq_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  fifoStrobes_t      strobes,
  input  logic [ADDR_W-1:0] phaseOffset,
  input  logic [DATA_W-1:0] wrI,
  input  logic [DATA_W-1:0] wrQ,
  output logic [DATA_W-1:0] rdI,
  output logic [DATA_W-1:0] rdQ,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] rdPtr,
  output logic [ADDR_W-1:0] wrPtrRdDom
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

  logic [DATA_W-1:0] memI [DEPTH];
  logic [DATA_W-1:0] memQ [DEPTH];

  // Write side
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] wrPtrNext;

  assign wrAddr = strobes.wrPtrLoad ? phaseOffset : wrPtr;

  always_comb begin
    if (strobes.wrPtrLoad)  wrPtrNext = strobes.wrEn ? phaseOffset + PTR_ONE : phaseOffset;
    else if (strobes.wrEn)  wrPtrNext = wrPtr + PTR_ONE;
    else                    wrPtrNext = wrPtr;
  end

  always_ff @(posedge wrClk) begin
    if (strobes.wrEn) begin
      memI[wrAddr] <= wrI;
      memQ[wrAddr] <= wrQ;
    end
  end

  logic [ADDR_W-1:0] wrGray;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrPtr  <= '0;
      wrGray <= '0;
    end else begin
      wrPtr  <= wrPtrNext;
      wrGray <= wrPtrNext ^ (wrPtrNext >> 1);
    end
  end

  // Crossing into the read domain
  logic [ADDR_W-1:0] graySync1;
  logic [ADDR_W-1:0] graySync2;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      graySync1 <= '0;
      graySync2 <= '0;
    end else begin
      graySync1 <= wrGray;
      graySync2 <= graySync1;
    end
  end

  for (genvar g = 0; g < ADDR_W; g++) begin : g_gray2bin
    assign wrPtrRdDom[g] = ^graySync2[ADDR_W-1:g];
  end

  // Read side
  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)                 rdPtr <= '0;
    else if (strobes.rdPtrClear) rdPtr <= '0;
    else if (strobes.rdEn)       rdPtr <= rdPtr + PTR_ONE;
  end

  assign rdI = memI[rdPtr];
  assign rdQ = memQ[rdPtr];

endmodule

// File: rtl/iq_phase_fifo.sv
`timescale 1ns/1ps
module iq_phase_fifo
  import iq_fifo_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3,
  parameter int LOAD_CYCLES = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrI,
  input  logic [DATA_W-1:0] wrQ,
  input  logic              frameIn,
  input  logic [ADDR_W-1:0] phaseOffset,
  input  logic              modeSel,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  input  logic              syncIn,
  input  logic              syncEdgeSel,
  output logic [DATA_W-1:0] rdI,
  output logic [DATA_W-1:0] rdQ,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] rdPtr,
  output logic [ADDR_W-1:0] wrPtrRdDom
);

  fifoStrobes_t strobes;

  iq_fifo_ctrl #(
    .LOAD_CYCLES(LOAD_CYCLES)
  ) u_ctrl (
    .wrClk       (wrClk),
    .wrRstN      (wrRstN),
    .wrEn        (wrEn),
    .frameIn     (frameIn),
    .modeSel     (modeSel),
    .rdClk       (rdClk),
    .rdRstN      (rdRstN),
    .rdEn        (rdEn),
    .syncIn      (syncIn),
    .syncEdgeSel (syncEdgeSel),
    .strobes     (strobes)
  );

  iq_fifo_dp #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .wrClk       (wrClk),
    .wrRstN      (wrRstN),
    .rdClk       (rdClk),
    .rdRstN      (rdRstN),
    .strobes     (strobes),
    .phaseOffset (phaseOffset),
    .wrI         (wrI),
    .wrQ         (wrQ),
    .rdI         (rdI),
    .rdQ         (rdQ),
    .wrPtr       (wrPtr),
    .rdPtr       (rdPtr),
    .wrPtrRdDom  (wrPtrRdDom)
  );

endmodule

// File: rtl/iq_phase_fifo_chk.sv
`timescale 1ns/1ps
module iq_phase_fifo_chk #(
  parameter int ADDR_W      = 3,
  parameter int LOAD_CYCLES = 2
) (
  input logic              wrClk,
  input logic              wrRstN,
  input logic              wrEn,
  input logic              frameIn,
  input logic              modeSel,
  input logic              rdClk,
  input logic              rdRstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] wrPtr,
  input logic [ADDR_W-1:0] rdPtr
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam bit MULTI_CYCLE = (LOAD_CYCLES > 1);

  // R1
  wr_step_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrEn && !frameIn) |=> wrPtr == $past(wrPtr) + ONE);

  // R1
  wr_hold_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (!wrEn && !frameIn) |=> $stable(wrPtr));

  // R5
  mode_off_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (modeSel && wrEn) |=> wrPtr == $past(wrPtr) + ONE);

  // R3
  first_frame_edge_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (MULTI_CYCLE && frameIn && !$past(frameIn) && wrEn) |=> wrPtr == $past(wrPtr) + ONE);

  // R7
  rd_step_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdRstN |=> (rdPtr == '0 || rdPtr == $past(rdPtr) || rdPtr == $past(rdPtr) + ONE));

  // R1
  rd_hold_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (!rdEn && rdPtr != '0) |=> (rdPtr == $past(rdPtr) || rdPtr == '0));

endmodule

bind iq_phase_fifo iq_phase_fifo_chk #(
  .ADDR_W(ADDR_W),
  .LOAD_CYCLES(LOAD_CYCLES)
) chk (
  .wrClk   (wrClk),
  .wrRstN  (wrRstN),
  .wrEn    (wrEn),
  .frameIn (frameIn),
  .modeSel (modeSel),
  .rdClk   (rdClk),
  .rdRstN  (rdRstN),
  .rdEn    (rdEn),
  .wrPtr   (wrPtr),
  .rdPtr   (rdPtr)
);

// File: tb/tb_iq_phase_fifo.sv
`timescale 1ns/1ps
module tb_iq_phase_fifo;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int NVEC   = 19;

  logic              wrClk, wrRstN, wrEn, frameIn, modeSel;
  logic [DATA_W-1:0] wrI, wrQ;
  logic [ADDR_W-1:0] phaseOffset;
  logic              rdClk, rdRstN, rdEn, syncIn, syncEdgeSel;
  logic [DATA_W-1:0] rdI, rdQ;
  logic [ADDR_W-1:0] wrPtr, rdPtr, wrPtrRdDom;

  int vecCnt  = 0;
  int failCnt = 0;

  logic [DATA_W-1:0] modelI [8];
  logic [DATA_W-1:0] modelQ [8];

  iq_phase_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOAD_CYCLES(2)) dut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrI(wrI), .wrQ(wrQ),
    .frameIn(frameIn), .phaseOffset(phaseOffset), .modeSel(modeSel),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .syncIn(syncIn),
    .syncEdgeSel(syncEdgeSel), .rdI(rdI), .rdQ(rdQ), .wrPtr(wrPtr),
    .rdPtr(rdPtr), .wrPtrRdDom(wrPtrRdDom)
  );

  // 250 MHz clocks; read clock lags by 1 ns.
  initial wrClk = 1'b0;
  always #2 wrClk = ~wrClk;
  initial begin
    rdClk = 1'b0;
    #1;
    forever #2 rdClk = ~rdClk;
  end

  // Fields: [8] frame, [7] wrEn, [6] modeSel, [5:3] offset, [2:0] expected wrPtr
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b0, 3'd5, 3'd1},  // R1 write advances
    {1'b0, 1'b1, 1'b0, 3'd5, 3'd2},
    {1'b1, 1'b1, 1'b0, 3'd5, 3'd3},  // R3 first frame cycle, no load
    {1'b0, 1'b1, 1'b0, 3'd5, 3'd4},  // R3 short frame ignored
    {1'b1, 1'b1, 1'b0, 3'd5, 3'd5},
    {1'b1, 1'b1, 1'b0, 3'd5, 3'd6},  // R2 R6 load with write -> offset+1
    {1'b1, 1'b1, 1'b0, 3'd5, 3'd7},  // R4 held frame, no reload
    {1'b1, 1'b0, 1'b0, 3'd5, 3'd7},  // R4
    {1'b0, 1'b1, 1'b0, 3'd5, 3'd0},  // R1 wrap 7 -> 0
    {1'b1, 1'b0, 1'b0, 3'd2, 3'd0},
    {1'b1, 1'b0, 1'b0, 3'd2, 3'd2},  // R2 R6 load without write -> offset
    {1'b0, 1'b0, 1'b0, 3'd2, 3'd2},
    {1'b1, 1'b1, 1'b1, 3'd6, 3'd3},  // R5 mode off
    {1'b1, 1'b1, 1'b1, 3'd6, 3'd4},  // R5
    {1'b1, 1'b1, 1'b1, 3'd6, 3'd5},  // R5
    {1'b0, 1'b0, 1'b0, 3'd6, 3'd5},
    {1'b1, 1'b0, 1'b0, 3'd7, 3'd5},
    {1'b1, 1'b0, 1'b0, 3'd7, 3'd7},  // R2 load offset 7
    {1'b0, 1'b1, 1'b0, 3'd7, 3'd0}   // R1 wrap after load
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  endtask

  // Sync restart: rise placed 0.5 ns after a read rising edge.
  task automatic syncRun(input logic edgeSel, input int clearEdge, input string req);
    logic [ADDR_W-1:0] startPtr;
    logic [ADDR_W-1:0] expPtr;
    @(negedge rdClk);
    syncEdgeSel = edgeSel;
    syncIn      = 1'b0;
    rdEn        = 1'b1;
    repeat (3) @(posedge rdClk);
    #0.5;
    startPtr = rdPtr;
    syncIn   = 1'b1;
    for (int n = 1; n <= 4; n++) begin
      @(posedge rdClk);
      #0.5;
      if (n < clearEdge) expPtr = startPtr + ADDR_W'(n);
      else               expPtr = ADDR_W'(n - clearEdge);
      check(req, rdPtr, expPtr);  // R7 held sync does not clear again
    end
    syncIn = 1'b0;
  endtask

  initial begin
    #100000;
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    wrRstN = 1'b0; rdRstN = 1'b0;
    wrEn = 1'b0; frameIn = 1'b0; modeSel = 1'b0; phaseOffset = '0;
    wrI = '0; wrQ = '0;
    rdEn = 1'b0; syncIn = 1'b0; syncEdgeSel = 1'b0;

    #10;
    check("R11 wrPtr", wrPtr, 0);
    check("R11 rdPtr", rdPtr, 0);
    check("R11 wrPtrRdDom", wrPtrRdDom, 0);

    @(negedge wrClk);
    wrRstN = 1'b1;
    rdRstN = 1'b1;

    // Table walk in the write domain
    for (int i = 0; i < NVEC; i++) begin
      @(negedge wrClk);
      frameIn     = VEC[i][8];
      wrEn        = VEC[i][7];
      modeSel     = VEC[i][6];
      phaseOffset = VEC[i][5:3];
      wrI         = DATA_W'(16'h1000 + i);
      wrQ         = DATA_W'(16'h2000 + i);
      @(posedge wrClk);
      #1;
      check($sformatf("R2-table step %0d wrPtr", i), wrPtr, VEC[i][2:0]);
      if (VEC[i][7]) begin
        modelI[VEC[i][2:0] - 3'd1] = DATA_W'(16'h1000 + i);
        modelQ[VEC[i][2:0] - 3'd1] = DATA_W'(16'h2000 + i);
      end
    end
    @(negedge wrClk);
    wrEn = 1'b0; frameIn = 1'b0; modeSel = 1'b0;

    // R9 read every slot, R1 read wrap
    for (int k = 0; k <= 8; k++) begin
      @(negedge rdClk);
      check("R1 rdPtr", rdPtr, k % 8);
      check("R9 rdI", rdI, modelI[k % 8]);
      check("R9 rdQ", rdQ, modelQ[k % 8]);
      rdEn = (k < 8);
    end

    // R10 crossing latency
    check("R10 settled", wrPtrRdDom, 0);
    @(negedge wrClk);
    wrEn = 1'b1;
    wrI  = 16'hABCD;
    wrQ  = 16'h5A5A;
    @(posedge wrClk);
    #1;
    wrEn = 1'b0;
    #1;
    check("R10 first read edge", wrPtrRdDom, 0);
    #4;
    check("R10 second read edge", wrPtrRdDom, 1);
    check("R1 wrPtr", wrPtr, 1);
    check("R9 rdI after write", rdI, 16'hABCD);
    check("R9 rdQ after write", rdQ, 16'h5A5A);

    // R8 both sampling edges
    syncRun(1'b0, 2, "R8 rising-edge sync");
    syncRun(1'b1, 1, "R8 falling-edge sync");

    finishRun();
  end

endmodule